// File: doc/BRIEF.md
# UART FIFO Control and Receive Trigger

This block sits beside one serial channel of a 16550-style UART. It holds the channel's write-only FIFO control byte and manages the two byte queues that buffer traffic between the host and the serial shift logic. The transmit queue is filled by the host and drained by the transmitter. The receive queue is filled by the receiver and drained by the host. Each queue has a level count, empty and full flags, and a registered output byte.

A single control write does several jobs. It switches both queues between a 16-entry buffered mode and a single-byte holding mode. It can flush either queue, through flush bits that clear themselves. It selects how many received bytes must be waiting before the receive interrupt is raised. It stores a DMA mode bit for other logic to use. Every field except the enable bit is taken only when the enable bit is written as 1 in the same write.

Top module: `uart_fifo_ctrl`

## Requirements
- R1: After reset both levels are 0, both empty flags are 1, both full flags are 0, and the receive interrupt, the DMA mode output and the FIFO enable output are all 0.
- R2: Control bit 0 sets the FIFO enable output. When it is 1, each queue holds up to 16 bytes. When it is 0, each queue holds one byte and reports full at level 1.
- R3: Control bits 1, 2, 3 and 7:6 act only when bit 0 is 1 in the same write; otherwise bit 3 and bits 7:6 keep their old values. Bits 5:4 have no effect.
- R4: Writing bit 1 (with bit 0) empties the receive queue on the clock edge after the write's edge. The transmit queue is not touched. The flush wins over a receive push in that cycle, and the flush bit clears itself, so later pushes are accepted.
- R5: Writing bit 2 (with bit 0) empties the transmit queue on the clock edge after the write's edge. The receive queue is not touched.
- R6: Bit 3 is stored and driven on the DMA mode output from the clock edge of the write onwards.
- R7: Bits 7:6 select the receive threshold: 00 gives 1, 01 gives 4, 10 gives 8 and 11 gives 14. The threshold is 1 while the FIFOs are disabled. The receive interrupt is 1 exactly when the receive level is at or above the threshold, in the same cycle as the level.
- R8: The receive interrupt drops as soon as the receive level falls below the threshold, whether the level falls through a pop or through a flush.
- R9: Each queue returns bytes in the order they were pushed. A push to a full queue is ignored, and the level never goes above the capacity.
- R10: A pop from an empty queue leaves the level at 0 and the output byte at the last byte popped.
- R11: A write that changes bit 0 empties both queues on the clock edge after the write's edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ctrl_we_i | input | 1 | Control register write strobe |
| ctrl_wdata_i | input | 8 | Control register write data |
| tx_push_i | input | 1 | Host pushes a byte into the transmit queue |
| tx_wdata_i | input | DATA_W | Byte to push into the transmit queue |
| tx_pop_i | input | 1 | Transmitter pops a byte from the transmit queue |
| tx_rdata_o | output | DATA_W | Last byte popped from the transmit queue |
| tx_level_o | output | LVL_W | Transmit queue level |
| tx_empty_o | output | 1 | Transmit queue empty |
| tx_full_o | output | 1 | Transmit queue full |
| rx_push_i | input | 1 | Receiver pushes a byte into the receive queue |
| rx_wdata_i | input | DATA_W | Byte to push into the receive queue |
| rx_pop_i | input | 1 | Host pops a byte from the receive queue |
| rx_rdata_o | output | DATA_W | Last byte popped from the receive queue |
| rx_level_o | output | LVL_W | Receive queue level |
| rx_empty_o | output | 1 | Receive queue empty |
| rx_full_o | output | 1 | Receive queue full |
| rx_irq_o | output | 1 | Receive threshold interrupt |
| dma_mode_o | output | 1 | Stored DMA mode bit |
| fifo_en_o | output | 1 | FIFO enable bit |

## Verification
Configuration outputs, levels, flags and popped bytes are registered once, so they change on the first clock edge after the strobe. The interrupt follows the level with no further delay. Flushes, whether requested explicitly or caused by an enable change, need two edges: one to register the flush pulse and one to clear the queue. The bench drives its inputs just after a falling edge and samples one falling edge after each edge that counts. For flushes, it checks the level both after the write's edge, where the level must be unchanged, and after the following edge, where it must be 0.

// File: rtl/uart_fifo_pkg.sv
package uart_fifo_pkg;
  localparam int unsigned CTRL_W = 8;

  typedef enum logic [1:0] {
    TRIG_1  = 2'd0,
    TRIG_4  = 2'd1,
    TRIG_8  = 2'd2,
    TRIG_14 = 2'd3
  } rx_trig_e;

  typedef struct packed {
    logic     en;
    logic     dma;
    rx_trig_e trig;
  } fifo_cfg_t;

  function automatic int unsigned trig_level(rx_trig_e t);
    case (t)
      TRIG_1:  return 1;
      TRIG_4:  return 4;
      TRIG_8:  return 8;
      default: return 14;
    endcase
  endfunction
endpackage

// File: rtl/fifo_ctrl_reg.sv
module fifo_ctrl_reg
  import uart_fifo_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [CTRL_W-1:0] wdata_i,
  output fifo_cfg_t         cfg_o,
  output logic              rx_clr_o,
  output logic              tx_clr_o
);
  localparam int unsigned B_EN   = 0;
  localparam int unsigned B_RCLR = 1;
  localparam int unsigned B_TCLR = 2;
  localparam int unsigned B_DMA  = 3;
  localparam int unsigned B_TRIG = 6;

  fifo_cfg_t cfg_q;
  logic      rx_clr_q, tx_clr_q;
  logic      mode_chg;

  assign mode_chg = we_i && (wdata_i[B_EN] != cfg_q.en);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q    <= '{en: 1'b0, dma: 1'b0, trig: TRIG_1};
      rx_clr_q <= 1'b0;
      tx_clr_q <= 1'b0;
    end else begin
      rx_clr_q <= mode_chg || (we_i && wdata_i[B_EN] && wdata_i[B_RCLR]);
      tx_clr_q <= mode_chg || (we_i && wdata_i[B_EN] && wdata_i[B_TCLR]);
      if (we_i) begin
        cfg_q.en <= wdata_i[B_EN];
        if (wdata_i[B_EN]) begin
          cfg_q.dma  <= wdata_i[B_DMA];
          cfg_q.trig <= rx_trig_e'(wdata_i[B_TRIG+1:B_TRIG]);
        end
      end
    end
  end

  assign cfg_o    = cfg_q;
  assign rx_clr_o = rx_clr_q;
  assign tx_clr_o = tx_clr_q;

  assert_gated_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && !wdata_i[B_EN]) |=> ($stable(cfg_q.dma) && $stable(cfg_q.trig)));
  assert_rx_selfclr_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_clr_q && !we_i) |=> !rx_clr_q);
  assert_tx_selfclr_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_clr_q && !we_i) |=> !tx_clr_q);
endmodule

// File: rtl/byte_fifo.sv
module byte_fifo #(
  parameter int unsigned DEPTH  = 16,
  parameter int unsigned DATA_W = 8,
  localparam int unsigned PTR_W = $clog2(DEPTH),
  localparam int unsigned LVL_W = $clog2(DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              deep_i,
  input  logic              clr_i,
  input  logic              push_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              pop_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic [LVL_W-1:0]  level_o,
  output logic              empty_o,
  output logic              full_o
);
  logic [DATA_W-1:0] mem_q [DEPTH];
  logic [PTR_W-1:0]  wr_ptr_q, rd_ptr_q;
  logic [LVL_W-1:0]  level_q, cap;
  logic [DATA_W-1:0] rdata_q;
  logic              push_ok, pop_ok;

  assign cap     = deep_i ? LVL_W'(DEPTH) : LVL_W'(1);
  assign empty_o = (level_q == '0);
  assign full_o  = (level_q >= cap);
  assign push_ok = push_i && !full_o;
  assign pop_ok  = pop_i && !empty_o;

  function automatic logic [PTR_W-1:0] ptr_inc(logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i) begin
    if (push_ok && !clr_i) mem_q[wr_ptr_q] <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      level_q  <= '0;
      rdata_q  <= '0;
    end else if (clr_i) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      level_q  <= '0;
    end else begin
      if (push_ok) wr_ptr_q <= ptr_inc(wr_ptr_q);
      if (pop_ok) begin
        rd_ptr_q <= ptr_inc(rd_ptr_q);
        rdata_q  <= mem_q[rd_ptr_q];
      end
      case ({push_ok, pop_ok})
        2'b10:   level_q <= level_q + 1'b1;
        2'b01:   level_q <= level_q - 1'b1;
        default: level_q <= level_q;
      endcase
    end
  end

  assign rdata_o = rdata_q;
  assign level_o = level_q;

  assert_no_overflow_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    level_q <= LVL_W'(DEPTH));
  assert_full_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && full_o && !pop_i && !clr_i) |=> (level_q == $past(level_q)));
  assert_clear_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (level_q == '0));
  assert_empty_pop_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_i && empty_o && !push_i && !clr_i) |=> ($stable(rdata_q) && level_q == '0));
endmodule

// File: rtl/rx_trigger.sv
module rx_trigger
  import uart_fifo_pkg::*;
#(
  parameter int unsigned LVL_W = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  rx_trig_e         trig_i,
  input  logic [LVL_W-1:0] level_i,
  output logic             irq_o
);
  logic [LVL_W-1:0] thresh;

  assign thresh = en_i ? LVL_W'(trig_level(trig_i)) : LVL_W'(1);
  assign irq_o  = (level_i >= thresh);

  assert_irq_nonempty_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (level_i != '0));
  assert_irq_top_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (level_i >= LVL_W'(14)) |-> irq_o);
endmodule

// File: rtl/uart_fifo_ctrl.sv
module uart_fifo_ctrl
  import uart_fifo_pkg::*;
#(
  parameter int unsigned DEPTH  = 16,
  parameter int unsigned DATA_W = 8,
  localparam int unsigned LVL_W = $clog2(DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ctrl_we_i,
  input  logic [7:0]        ctrl_wdata_i,
  input  logic              tx_push_i,
  input  logic [DATA_W-1:0] tx_wdata_i,
  input  logic              tx_pop_i,
  output logic [DATA_W-1:0] tx_rdata_o,
  output logic [LVL_W-1:0]  tx_level_o,
  output logic              tx_empty_o,
  output logic              tx_full_o,
  input  logic              rx_push_i,
  input  logic [DATA_W-1:0] rx_wdata_i,
  input  logic              rx_pop_i,
  output logic [DATA_W-1:0] rx_rdata_o,
  output logic [LVL_W-1:0]  rx_level_o,
  output logic              rx_empty_o,
  output logic              rx_full_o,
  output logic              rx_irq_o,
  output logic              dma_mode_o,
  output logic              fifo_en_o
);
  fifo_cfg_t cfg;
  logic      rx_clr, tx_clr;

  fifo_ctrl_reg u_ctrl (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .we_i     (ctrl_we_i),
    .wdata_i  (ctrl_wdata_i),
    .cfg_o    (cfg),
    .rx_clr_o (rx_clr),
    .tx_clr_o (tx_clr)
  );

  byte_fifo #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_tx_fifo (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .deep_i  (cfg.en),
    .clr_i   (tx_clr),
    .push_i  (tx_push_i),
    .wdata_i (tx_wdata_i),
    .pop_i   (tx_pop_i),
    .rdata_o (tx_rdata_o),
    .level_o (tx_level_o),
    .empty_o (tx_empty_o),
    .full_o  (tx_full_o)
  );

  byte_fifo #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_rx_fifo (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .deep_i  (cfg.en),
    .clr_i   (rx_clr),
    .push_i  (rx_push_i),
    .wdata_i (rx_wdata_i),
    .pop_i   (rx_pop_i),
    .rdata_o (rx_rdata_o),
    .level_o (rx_level_o),
    .empty_o (rx_empty_o),
    .full_o  (rx_full_o)
  );

  rx_trigger #(.LVL_W(LVL_W)) u_trig (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .en_i    (cfg.en),
    .trig_i  (cfg.trig),
    .level_i (rx_level_o),
    .irq_o   (rx_irq_o)
  );

  assign dma_mode_o = cfg.dma;
  assign fifo_en_o  = cfg.en;
endmodule

// File: tb/uart_fifo_ctrl_tb_top.sv
module uart_fifo_ctrl_tb_top;
  localparam int unsigned DEPTH  = 16;
  localparam int unsigned DATA_W = 8;
  localparam int unsigned LVL_W  = $clog2(DEPTH + 1);

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              ctrl_we = 1'b0;
  logic [7:0]        ctrl_wdata = '0;
  logic              tx_push = 1'b0, tx_pop = 1'b0, rx_push = 1'b0, rx_pop = 1'b0;
  logic [DATA_W-1:0] tx_wdata = '0, rx_wdata = '0;
  logic [DATA_W-1:0] tx_rdata, rx_rdata;
  logic [LVL_W-1:0]  tx_level, rx_level;
  logic              tx_empty, tx_full, rx_empty, rx_full, rx_irq, dma_mode, fifo_en;

  int unsigned n_checks = 0;
  int unsigned n_fail   = 0;
  bit          done     = 1'b0;

  always #10 clk = ~clk;

  uart_fifo_ctrl #(.DEPTH(DEPTH), .DATA_W(DATA_W)) dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .ctrl_we_i(ctrl_we), .ctrl_wdata_i(ctrl_wdata),
    .tx_push_i(tx_push), .tx_wdata_i(tx_wdata), .tx_pop_i(tx_pop),
    .tx_rdata_o(tx_rdata), .tx_level_o(tx_level), .tx_empty_o(tx_empty), .tx_full_o(tx_full),
    .rx_push_i(rx_push), .rx_wdata_i(rx_wdata), .rx_pop_i(rx_pop),
    .rx_rdata_o(rx_rdata), .rx_level_o(rx_level), .rx_empty_o(rx_empty), .rx_full_o(rx_full),
    .rx_irq_o(rx_irq), .dma_mode_o(dma_mode), .fifo_en_o(fifo_en)
  );

  task automatic check(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  // Write, then wait one more edge so any flush pulse has landed.
  task automatic wr(input logic [7:0] v);
    ctrl_we = 1'b1; ctrl_wdata = v;
    tick();
    ctrl_we = 1'b0;
    tick();
  endtask

  task automatic push_rx(input logic [7:0] d);
    rx_push = 1'b1; rx_wdata = d; tick(); rx_push = 1'b0;
  endtask
  task automatic push_tx(input logic [7:0] d);
    tx_push = 1'b1; tx_wdata = d; tick(); tx_push = 1'b0;
  endtask
  task automatic pop_rx();
    rx_pop = 1'b1; tick(); rx_pop = 1'b0;
  endtask
  task automatic pop_tx();
    tx_pop = 1'b1; tick(); tx_pop = 1'b0;
  endtask

  function automatic int thr_of(input int t);
    case (t)
      0: return 1;
      1: return 4;
      2: return 8;
      default: return 14;
    endcase
  endfunction

  task automatic t_reset();
    check("R1 tx_level", int'(tx_level), 0);
    check("R1 rx_level", int'(rx_level), 0);
    check("R1 empties", int'({tx_empty, rx_empty}), 3);
    check("R1 fulls", int'({tx_full, rx_full}), 0);
    check("R1 irq/dma/en", int'({rx_irq, dma_mode, fifo_en}), 0);
  endtask

  task automatic t_disabled_hold();
    push_rx(8'h11);
    check("R2 disabled level", int'(rx_level), 1);
    check("R2 disabled full", int'(rx_full), 1);
    check("R7 disabled irq", int'(rx_irq), 1);
    push_rx(8'h22);
    check("R9 push on full ignored", int'(rx_level), 1);
    pop_rx();
    check("R9 holding data", int'(rx_rdata), 'h11);
    check("R8 irq after pop", int'(rx_irq), 0);
  endtask

  task automatic t_deep_order();
    wr(8'h01);
    check("R2 enable out", int'(fifo_en), 1);
    for (int i = 0; i < 16; i++) push_tx(8'(i * 3 + 1));
    check("R2 deep level", int'(tx_level), 16);
    check("R9 full flag", int'(tx_full), 1);
    push_tx(8'hEE);
    check("R9 overflow ignored", int'(tx_level), 16);
    for (int i = 0; i < 16; i++) begin
      pop_tx();
      check("R9 order", int'(tx_rdata), (i * 3 + 1) & 'hFF);
    end
    pop_tx();
    check("R10 empty pop data", int'(tx_rdata), 46);
    check("R10 empty pop level", int'(tx_level), 0);
  endtask

  task automatic t_gating();
    wr(8'hC9);
    check("R6 dma set", int'(dma_mode), 1);
    wr(8'h00);
    check("R3 disable write", int'(fifo_en), 0);
    check("R3 dma kept", int'(dma_mode), 1);
    wr(8'h01);
    check("R6 dma cleared", int'(dma_mode), 0);
    push_rx(8'h5A);
    wr(8'h31);
    check("R3 reserved bits no flush", int'(rx_level), 1);
    check("R3 reserved dma", int'(dma_mode), 0);
    check("R7 trig 00 irq", int'(rx_irq), 1);
  endtask

  task automatic t_trigger();
    for (int t = 0; t < 4; t++) begin
      wr(8'(8'h03 | (t << 6)));
      check("R4 flush before trig run", int'(rx_level), 0);
      for (int n = 1; n <= 14; n++) begin
        push_rx(8'(n));
        check($sformatf("R7 trig %0d level %0d", t, n), int'(rx_irq), int'(n >= thr_of(t)));
      end
      for (int n = 13; n >= thr_of(t) - 1; n--) begin
        pop_rx();
        check($sformatf("R8 trig %0d level %0d", t, n), int'(rx_irq), int'(n >= thr_of(t)));
      end
    end
  endtask

  task automatic t_rx_flush();
    wr(8'h83);
    wr(8'h85);
    for (int i = 0; i < 9; i++) push_rx(8'(8'h40 + i));
    for (int i = 0; i < 3; i++) push_tx(8'(8'h70 + i));
    check("R7 trig 10 irq", int'(rx_irq), 1);
    ctrl_we = 1'b1; ctrl_wdata = 8'h83;
    tick();
    check("R4 not yet flushed", int'(rx_level), 9);
    ctrl_we = 1'b0; rx_push = 1'b1; rx_wdata = 8'h55;
    tick();
    rx_push = 1'b0;
    check("R4 flushed, push lost", int'(rx_level), 0);
    check("R8 irq after flush", int'(rx_irq), 0);
    check("R4 tx untouched", int'(tx_level), 3);
    push_rx(8'h66);
    check("R4 self-cleared", int'(rx_level), 1);
  endtask

  task automatic t_tx_flush();
    ctrl_we = 1'b1; ctrl_wdata = 8'h85;
    tick();
    ctrl_we = 1'b0;
    check("R5 not yet flushed", int'(tx_level), 3);
    tick();
    check("R5 tx flushed", int'(tx_level), 0);
    check("R5 rx untouched", int'(rx_level), 1);
  endtask

  task automatic t_mode_change();
    push_tx(8'h01);
    push_tx(8'h02);
    ctrl_we = 1'b1; ctrl_wdata = 8'h00;
    tick();
    ctrl_we = 1'b0;
    check("R11 enable dropped", int'(fifo_en), 0);
    check("R11 rx before flush", int'(rx_level), 1);
    tick();
    check("R11 rx flushed", int'(rx_level), 0);
    check("R11 tx flushed", int'(tx_level), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_disabled_hold();
    t_deep_order();
    t_gating();
    t_trigger();
    t_rx_flush();
    t_tx_flush();
    t_mode_change();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end
endmodule